// File: doc/BRIEF.md
# Dual-Device Control Register Mux

This block holds the discrete control pins for two identical serial-bus terminal devices behind a small memory-mapped register port. Each device has an enable for each of three functions: bus controller, remote terminal and monitor. Each device also has a bus-controller trigger. Software selects a device with a channel input and writes one bit per pin. Every pin can be read back as it is actually being driven.

A single global mode bit sets where the bus-controller enable and trigger come from. In demo mode, which is the state after reset, both come from software registers. The enables are preset on, so every terminal function of both devices works with no setup. In user mode, these two pins follow external connector inputs instead. The connector enable is active low, so an open or pulled-up pin keeps the bus controller off. The remote-terminal and monitor enables stay under software control in both modes.

Top module: `dual_dev_ctrl_mux`

## Requirements
- R1: The register window covers addresses 0x8000 to 0x8013. A write outside it, or to a reserved or read-only offset inside it, changes no pin. A read outside the window, or of a reserved offset, returns zero.
- R2: After reset the mode is demo (0). The bus-controller, remote-terminal and monitor enables of both devices are 1. Both triggers are 0.
- R3: Per-device offsets are 0x00 bus-controller enable, 0x01 remote-terminal enable, 0x02 monitor enable and 0x03 trigger. Bit 0 of the write data sets the pin level. chanSel 0 or 1 picks device 0 or 1, and the other device is untouched.
- R4: The mode register sits at offset 0x0D (address 0x800D) and is global, whatever chanSel is. Writing 0 selects demo mode and writing 1 selects user mode. It reads back at that offset.
- R5: In demo mode, each device's bus-controller enable and trigger outputs follow that device's software register bits.
- R6: In user mode, bcEnaOut[d] is the inverse of the synchronized connBcEnaN[d], and bcTrigOut[d] is the synchronized connBcTrig[d]. Writes to offsets 0x00 and 0x03 are stored but do not reach the outputs until demo mode returns.
- R7: Connector inputs pass through a two-flop synchronizer. A pin change shows at the output after the second rising edge, not after the first. The synchronizer resets to enable inactive (high) and trigger low.
- R8: The remote-terminal and monitor enables follow software in both modes, and they are independent per device.
- R9: A read strobe gives rdValid and rdData one cycle later. For offsets 0x00 to 0x03, bit 0 is the pin level being driven for the selected device. Offsets 0x04 and 0x05 return the synchronized raw connector enable and trigger levels. All upper bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | One-cycle write strobe |
| rdEn | input | 1 | One-cycle read strobe |
| addr | input | ADDR_W (16) | Register word address |
| chanSel | input | DEV_W (1) | Device select |
| wrData | input | DATA_W (16) | Write data, bit 0 used |
| rdData | output | DATA_W (16) | Registered read data |
| rdValid | output | 1 | Read data valid |
| connBcEnaN | input | NUM_DEV (2) | Connector bus-controller enable, active low |
| connBcTrig | input | NUM_DEV (2) | Connector bus-controller trigger |
| bcEnaOut | output | NUM_DEV (2) | Bus-controller enable pins |
| bcTrigOut | output | NUM_DEV (2) | Bus-controller trigger pins |
| rtEnaOut | output | NUM_DEV (2) | Remote-terminal enable pins |
| mtEnaOut | output | NUM_DEV (2) | Monitor enable pins |

## Verification
The bench writes a bus-controller enable while in user mode, then checks that the output still follows the connector. A design that muxed on the write path instead of the output would let software override the pin. The bench samples one edge after a connector change and expects the old value, which catches a synchronizer that is missing a stage or has one too many. It checks that a return to demo mode restores the value stored during user mode, and that addresses just past each end of the window neither write nor read. A decoder with an off-by-one bound would corrupt a pin or return stale data there.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  // Register selector produced by address decode
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_BC_ENA,
    SEL_RT_ENA,
    SEL_MT_ENA,
    SEL_BC_TRIG,
    SEL_CONN_ENA,
    SEL_CONN_TRIG,
    SEL_MODE
  } regSel_e;

  // Word offsets inside the window; the register behaviour depends on them
  localparam int OFS_BC_ENA    = 0;
  localparam int OFS_RT_ENA    = 1;
  localparam int OFS_MT_ENA    = 2;
  localparam int OFS_BC_TRIG   = 3;
  localparam int OFS_CONN_ENA  = 4;
  localparam int OFS_CONN_TRIG = 5;
  localparam int OFS_MODE      = 13;

  // Strobes from control to datapath
  typedef struct packed {
    logic    wrStb;
    logic    rdStb;
    regSel_e sel;
    logic    wrBit;
  } ctrlStb_t;

endpackage

// File: rtl/dcr_sync.sv
module dcr_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
  import dcr_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 16,
  parameter int              NUM_DEV   = 2,
  parameter int              DEV_W     = 1,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000,
  parameter int              WIN_WORDS = 20
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DEV_W-1:0]  chanSel,
  output ctrlStb_t          stb,
  output logic [DEV_W-1:0]  devIdx
);

  localparam logic [ADDR_W:0] WIN_LO = {1'b0, BASE_ADDR};
  localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W+1)'(WIN_WORDS);

  logic              inWin;
  logic              devOk;
  logic [ADDR_W-1:0] ofs;
  regSel_e           sel;
  logic              writable;

  assign inWin  = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
  assign devOk  = (32'(chanSel) < NUM_DEV);
  assign ofs    = addr - BASE_ADDR;
  assign devIdx = chanSel;

  always_comb begin
    sel = SEL_NONE;
    if (inWin) begin
      if (32'(ofs) == OFS_MODE)               sel = SEL_MODE;
      else if (devOk) begin
        case (32'(ofs))
          OFS_BC_ENA:    sel = SEL_BC_ENA;
          OFS_RT_ENA:    sel = SEL_RT_ENA;
          OFS_MT_ENA:    sel = SEL_MT_ENA;
          OFS_BC_TRIG:   sel = SEL_BC_TRIG;
          OFS_CONN_ENA:  sel = SEL_CONN_ENA;
          OFS_CONN_TRIG: sel = SEL_CONN_TRIG;
          default:       sel = SEL_NONE;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_BC_ENA, SEL_RT_ENA, SEL_MT_ENA,
      SEL_BC_TRIG, SEL_MODE: writable = 1'b1;
      default:               writable = 1'b0;
    endcase
  end

  always_comb begin
    stb.wrStb = wrEn && writable;
    stb.rdStb = rdEn;
    stb.sel   = sel;
    stb.wrBit = wrData[0];
  end

endmodule

// File: rtl/dcr_datapath.sv
module dcr_datapath
  import dcr_pkg::*;
#(
  parameter int NUM_DEV     = 2,
  parameter int DEV_W       = 1,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic [DEV_W-1:0]   devIdx,
  input  logic [NUM_DEV-1:0] connBcEnaN,
  input  logic [NUM_DEV-1:0] connBcTrig,
  output logic [NUM_DEV-1:0] bcEnaOut,
  output logic [NUM_DEV-1:0] bcTrigOut,
  output logic [NUM_DEV-1:0] rtEnaOut,
  output logic [NUM_DEV-1:0] mtEnaOut,
  output logic               userMode,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid
);

  logic [NUM_DEV-1:0] bcEnaReg, rtEnaReg, mtEnaReg, bcTrigReg;
  logic [NUM_DEV-1:0] syncEnaN, syncTrig;
  logic               modeReg;
  logic               rdBit;

  dcr_sync #(.WIDTH(NUM_DEV), .STAGES(SYNC_STAGES), .RST_VAL({NUM_DEV{1'b1}}))
    syncEna_i (.clk(clk), .rstN(rstN), .din(connBcEnaN), .dout(syncEnaN));

  dcr_sync #(.WIDTH(NUM_DEV), .STAGES(SYNC_STAGES), .RST_VAL({NUM_DEV{1'b0}}))
    syncTrig_i (.clk(clk), .rstN(rstN), .din(connBcTrig), .dout(syncTrig));

  // Global mode bit, demo after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  modeReg <= 1'b0;
    else if (stb.wrStb && stb.sel == SEL_MODE)  modeReg <= stb.wrBit;
  end

  // Per-device pin registers with demo presets
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic hit;
    assign hit = stb.wrStb && (devIdx == DEV_W'(d));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bcEnaReg[d]  <= 1'b1;
        rtEnaReg[d]  <= 1'b1;
        mtEnaReg[d]  <= 1'b1;
        bcTrigReg[d] <= 1'b0;
      end else if (hit) begin
        case (stb.sel)
          SEL_BC_ENA:  bcEnaReg[d]  <= stb.wrBit;
          SEL_RT_ENA:  rtEnaReg[d]  <= stb.wrBit;
          SEL_MT_ENA:  mtEnaReg[d]  <= stb.wrBit;
          SEL_BC_TRIG: bcTrigReg[d] <= stb.wrBit;
          default: ;
        endcase
      end
    end

    // Output mux: connector pins win in user mode
    assign bcEnaOut[d]  = modeReg ? ~syncEnaN[d] : bcEnaReg[d];
    assign bcTrigOut[d] = modeReg ?  syncTrig[d] : bcTrigReg[d];
  end

  assign rtEnaOut = rtEnaReg;
  assign mtEnaOut = mtEnaReg;
  assign userMode = modeReg;

  always_comb begin
    case (stb.sel)
      SEL_BC_ENA:    rdBit = bcEnaOut[devIdx];
      SEL_RT_ENA:    rdBit = rtEnaOut[devIdx];
      SEL_MT_ENA:    rdBit = mtEnaOut[devIdx];
      SEL_BC_TRIG:   rdBit = bcTrigOut[devIdx];
      SEL_CONN_ENA:  rdBit = syncEnaN[devIdx];
      SEL_CONN_TRIG: rdBit = syncTrig[devIdx];
      SEL_MODE:      rdBit = modeReg;
      default:       rdBit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdStb;
      rdData  <= stb.rdStb ? DATA_W'(rdBit) : '0;
    end
  end

endmodule

// File: rtl/dual_dev_ctrl_mux.sv
module dual_dev_ctrl_mux
  import dcr_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 16,
  parameter int                NUM_DEV     = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h8000,
  parameter int                WIN_WORDS   = 20,
  parameter int                SYNC_STAGES = 2,
  localparam int               DEV_W       = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DEV_W-1:0]   chanSel,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid,
  input  logic [NUM_DEV-1:0] connBcEnaN,
  input  logic [NUM_DEV-1:0] connBcTrig,
  output logic [NUM_DEV-1:0] bcEnaOut,
  output logic [NUM_DEV-1:0] bcTrigOut,
  output logic [NUM_DEV-1:0] rtEnaOut,
  output logic [NUM_DEV-1:0] mtEnaOut
);

  ctrlStb_t         stb;
  logic [DEV_W-1:0] devIdx;
  logic             userMode;

  dcr_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DEV(NUM_DEV), .DEV_W(DEV_W),
    .BASE_ADDR(BASE_ADDR), .WIN_WORDS(WIN_WORDS)
  ) ctrl_i (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .chanSel(chanSel), .stb(stb), .devIdx(devIdx)
  );

  dcr_datapath #(
    .NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .devIdx(devIdx),
    .connBcEnaN(connBcEnaN), .connBcTrig(connBcTrig),
    .bcEnaOut(bcEnaOut), .bcTrigOut(bcTrigOut),
    .rtEnaOut(rtEnaOut), .mtEnaOut(mtEnaOut),
    .userMode(userMode), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/dual_dev_ctrl_mux_chk.sv
module dual_dev_ctrl_mux_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter int                NUM_DEV   = 2,
  parameter int                DEV_W     = 1,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000,
  parameter int                WIN_WORDS = 20
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DEV_W-1:0]   chanSel,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic               rdValid,
  input logic [NUM_DEV-1:0] connBcEnaN,
  input logic [NUM_DEV-1:0] connBcTrig,
  input logic [NUM_DEV-1:0] bcEnaOut,
  input logic [NUM_DEV-1:0] bcTrigOut,
  input logic [NUM_DEV-1:0] rtEnaOut,
  input logic [NUM_DEV-1:0] mtEnaOut,
  input logic               userMode
);

  logic [1:0] warm;
  logic       outWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warm <= '0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  assign outWin = ({1'b0, addr} < {1'b0, BASE_ADDR}) ||
                  ({1'b0, addr} >= ({1'b0, BASE_ADDR} + (ADDR_W+1)'(WIN_WORDS)));

  // R2
  reset_preset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (rtEnaOut == '1 && mtEnaOut == '1 && bcEnaOut == '1 &&
                      bcTrigOut == '0 && !userMode));

  // R9
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  // R1
  outside_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && outWin) |=> rdData == '0);

  // R1
  outside_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && outWin && !rdEn) |=> ($stable(rtEnaOut) && $stable(mtEnaOut) && $stable(userMode)));

  // R6
  user_bc_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (userMode && warm >= 2'd2) |-> bcEnaOut == ~$past(connBcEnaN, 2));

  // R7
  user_trigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    (userMode && warm >= 2'd2) |-> bcTrigOut == $past(connBcTrig, 2));

  // R8
  rt_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == BASE_ADDR + ADDR_W'(1) && chanSel == '0) |=> rtEnaOut[0] == $past(wrData[0]));

endmodule

bind dual_dev_ctrl_mux dual_dev_ctrl_mux_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DEV(NUM_DEV), .DEV_W(DEV_W),
  .BASE_ADDR(BASE_ADDR), .WIN_WORDS(WIN_WORDS)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .chanSel(chanSel), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
  .connBcEnaN(connBcEnaN), .connBcTrig(connBcTrig),
  .bcEnaOut(bcEnaOut), .bcTrigOut(bcTrigOut), .rtEnaOut(rtEnaOut),
  .mtEnaOut(mtEnaOut), .userMode(userMode)
);

// File: tb/dual_dev_ctrl_mux_tb_top.sv
module dual_dev_ctrl_mux_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] addr = '0;
  logic        chanSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        rdValid;
  logic [1:0]  connBcEnaN = 2'b11;
  logic [1:0]  connBcTrig = 2'b00;
  logic [1:0]  bcEnaOut, bcTrigOut, rtEnaOut, mtEnaOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  dual_dev_ctrl_mux dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .chanSel(chanSel), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .connBcEnaN(connBcEnaN), .connBcTrig(connBcTrig),
    .bcEnaOut(bcEnaOut), .bcTrigOut(bcTrigOut),
    .rtEnaOut(rtEnaOut), .mtEnaOut(mtEnaOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic ch, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; chanSel = ch;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic ch, input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a; chanSel = ch;
    @(negedge clk);
    rdEn = 1'b0;
    check("R9 rdValid", {15'd0, rdValid}, 16'd1);
    d = rdData;
  endtask

  task automatic testReset();
    logic [15:0] v;
    check("R2 bcEna", {14'd0, bcEnaOut}, 16'd3);
    check("R2 rtEna", {14'd0, rtEnaOut}, 16'd3);
    check("R2 mtEna", {14'd0, mtEnaOut}, 16'd3);
    check("R2 trig",  {14'd0, bcTrigOut}, 16'd0);
    regRead(1'b1, 16'h800D, v);
    check("R4 R2 mode after reset", v, 16'd0);
  endtask

  task automatic testDemoWrites();
    logic [15:0] v;
    regWrite(1'b1, 16'h8000, 16'hFFFE);
    check("R3 R5 bcEna dev1 cleared", {14'd0, bcEnaOut}, 16'd1);
    regWrite(1'b0, 16'h8003, 16'd1);
    check("R5 trig dev0 set", {14'd0, bcTrigOut}, 16'd1);
    regRead(1'b1, 16'h8000, v);
    check("R9 read bcEna dev1", v, 16'd0);
    regRead(1'b0, 16'h8003, v);
    check("R9 read trig dev0", v, 16'd1);
  endtask

  task automatic testUserMode();
    logic [15:0] v;
    regWrite(1'b1, 16'h800D, 16'd1);
    regRead(1'b0, 16'h800D, v);
    check("R4 mode global read", v, 16'd1);
    check("R6 bcEna disabled open pins", {14'd0, bcEnaOut}, 16'd0);
    check("R6 trig from connector", {14'd0, bcTrigOut}, 16'd0);
    @(negedge clk);
    connBcEnaN = 2'b10;
    connBcTrig = 2'b10;
    @(negedge clk);
    check("R7 one edge no change", {14'd0, bcEnaOut}, 16'd0);
    @(negedge clk);
    check("R7 R6 second edge enable", {14'd0, bcEnaOut}, 16'd1);
    check("R7 R6 second edge trig", {14'd0, bcTrigOut}, 16'd2);
    regWrite(1'b1, 16'h8000, 16'd1);
    check("R6 reg write ignored at pin", {14'd0, bcEnaOut}, 16'd1);
    regRead(1'b0, 16'h8000, v);
    check("R9 read driven bcEna dev0", v, 16'd1);
    regRead(1'b1, 16'h8004, v);
    check("R9 read raw connector enable", v, 16'd1);
  endtask

  task automatic testUserRtMt();
    regWrite(1'b0, 16'h8001, 16'd0);
    check("R8 rt dev0 off", {14'd0, rtEnaOut}, 16'd2);
    regWrite(1'b1, 16'h8002, 16'd0);
    check("R8 mt dev1 off", {14'd0, mtEnaOut}, 16'd1);
    check("R8 rt untouched", {14'd0, rtEnaOut}, 16'd2);
  endtask

  task automatic testWindow();
    logic [15:0] v;
    regWrite(1'b1, 16'h8014, 16'd0);
    regWrite(1'b1, 16'h7FFF, 16'd0);
    regWrite(1'b1, 16'h8004, 16'd0);
    check("R1 rt after outside writes", {14'd0, rtEnaOut}, 16'd2);
    regRead(1'b1, 16'h800D, v);
    check("R1 mode kept", v, 16'd1);
    regRead(1'b1, 16'h8014, v);
    check("R1 read above window", v, 16'd0);
    regRead(1'b0, 16'h7FFF, v);
    check("R1 read below window", v, 16'd0);
    regRead(1'b0, 16'h8007, v);
    check("R1 reserved offset", v, 16'd0);
    regRead(1'b1, 16'h8013, v);
    check("R1 last word reserved", v, 16'd0);
  endtask

  task automatic testBackToDemo();
    regWrite(1'b0, 16'h800D, 16'd0);
    check("R5 demo restores stored bcEna", {14'd0, bcEnaOut}, 16'd3);
    check("R5 demo restores stored trig", {14'd0, bcTrigOut}, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDemoWrites();
    testUserMode();
    testUserRtMt();
    testWindow();
    testBackToDemo();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule